// File: doc/BRIEF.md
# Tagged Polymorphic Integer ALU

This block is an integer execution unit in which every operand travels with a small type tag beside its 64-bit value. The opcode names only a generic operation: add, subtract, bitwise and/or/xor, less-than, equality, or cast. The tags of the operands choose the width, the signedness and the extension rule. A single encoding of each operation therefore serves every integer width and signedness.

Each operand is first brought to canonical form under its own tag. The operation then runs at full width. The result is canonicalised under the result tag, and both the value and the tag are returned. That tag is the joined tag for arithmetic and logic, a fixed boolean tag for compares, and an immediate target tag for casts. A presence mask tells the unit which operands arrive. An add that receives only its first operand becomes an increment in that operand's own type.

The unit has one register stage. A result appears one clock after the request, together with a valid flag and an illegal-type flag.

Top module: `tagged_alu`

## Requirements
- R1: Tags are 4-bit codes: 0..3 are unsigned 8/16/32/64-bit, 4..7 are signed 8/16/32/64-bit, and 8 is a pointer (64-bit, unsigned). Codes 9..15 are reserved. A reserved tag on operand a, on a present operand b (any opcode except cast), or as the cast target sets illegal_o, and the result is then value 0 with tag 0.
- R2: Opcodes are 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 less-than, 6 equal, 7 cast. Each operand is truncated to its own tag's width and then extended by that tag's signedness before the operation is applied.
- R3: For add/sub/and/or/xor, the result tag is joined from the operand tags in this order. A pointer on either side gives a pointer. Otherwise the wider width wins. At equal width with mixed signedness, the unsigned tag of that width is used.
- R4: Every legal result is canonical: it is truncated to the width of its tag, then sign-extended (signed tags) or zero-extended (all other tags) to 64 bits.
- R5: An add with only operand a present (present_i = 2'b01) returns a+1, wrapped in a's own type, with a's tag.
- R6: A cast returns operand a, already canonical under its own tag, re-canonicalised under cast_tag_i. Its result tag is cast_tag_i, and operand b plays no part.
- R7: Less-than and equal return value 0 or 1 with tag 0 (unsigned 8-bit). Less-than is signed exactly when a's tag is signed. Equal compares the canonical forms of the two operands.
- R8: The result appears one cycle after in_valid_i, with res_valid_o high for that cycle only. Reset clears every output to zero.
- R9: A request without operand a, or without operand b for any opcode except add and cast, sets illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Generic opcode |
| present_i | input | 2 | Operand presence: bit 0 a, bit 1 b |
| a_val_i | input | DATA_W | Operand a value |
| a_tag_i | input | 4 | Operand a tag |
| b_val_i | input | DATA_W | Operand b value |
| b_tag_i | input | 4 | Operand b tag |
| cast_tag_i | input | 4 | Target tag for cast |
| res_valid_o | output | 1 | Result strobe |
| res_val_o | output | DATA_W | Result value, canonical |
| res_tag_o | output | 4 | Result tag |
| illegal_o | output | 1 | Reserved tag or missing operand |

## Verification
The bench builds the unit with DATA_W at its default of 64, the only width the tag code space describes. At that width, all four extension widths are reached. This includes the full-width case, where truncation and extension leave the value unchanged, alongside the 8/16/32-bit cases where upper bits are either replicated or cleared. The directed vectors place garbage in the upper bits of narrow operands, mix signedness at equal width, and wrap increments at the top of each type. They also cast across widths in both directions and send reserved codes through each path that can detect them.

// File: rtl/tagged_alu_pkg.sv
`timescale 1ns/1ps
package tagged_alu_pkg;
  localparam int TAG_W = 4;
  localparam int OP_W  = 3;
  localparam int NUM_W = 4;

  localparam logic [TAG_W-1:0] T_U8  = 4'd0;
  localparam logic [TAG_W-1:0] T_U64 = 4'd3;
  localparam logic [TAG_W-1:0] T_I16 = 4'd5;
  localparam logic [TAG_W-1:0] T_PTR = 4'd8;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_LT, OP_EQ, OP_CAST
  } op_e;

  function automatic logic tag_ok(input logic [TAG_W-1:0] t);
    return t <= T_PTR;
  endfunction

  function automatic logic [1:0] tag_wc(input logic [TAG_W-1:0] t);
    return (t == T_PTR) ? 2'd3 : t[1:0];
  endfunction

  function automatic logic tag_sgn(input logic [TAG_W-1:0] t);
    return !t[3] && t[2];
  endfunction
endpackage

// File: rtl/tag_canon.sv
`timescale 1ns/1ps
module tag_canon
  import tagged_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] ext [NUM_W];
  logic              sgn;

  assign sgn = tag_sgn(tag_i);

  for (genvar k = 0; k < NUM_W; k++) begin : g_w
    localparam int W = 8 << k;
    if (W < DATA_W) begin : g_cut
      assign ext[k] = {{(DATA_W-W){sgn & val_i[W-1]}}, val_i[W-1:0]};
    end else begin : g_full
      assign ext[k] = val_i;
    end
  end

  assign val_o = ext[tag_wc(tag_i)];
endmodule

// File: rtl/tag_join.sv
`timescale 1ns/1ps
module tag_join
  import tagged_alu_pkg::*;
(
  input  logic [TAG_W-1:0] a_tag_i,
  input  logic [TAG_W-1:0] b_tag_i,
  output logic [TAG_W-1:0] tag_o
);
  logic [1:0] wa, wb;

  assign wa = tag_wc(a_tag_i);
  assign wb = tag_wc(b_tag_i);

  always_comb begin
    if (a_tag_i == T_PTR || b_tag_i == T_PTR) tag_o = T_PTR;
    else if (wa > wb)                         tag_o = a_tag_i;
    else if (wb > wa)                         tag_o = b_tag_i;
    else if (tag_sgn(a_tag_i) == tag_sgn(b_tag_i)) tag_o = a_tag_i;
    else                                      tag_o = {2'b00, wa}; // unsigned of same width
  end
endmodule

// File: rtl/tagged_alu_core.sv
`timescale 1ns/1ps
module tagged_alu_core
  import tagged_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        present_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [TAG_W-1:0]  cast_tag_i,
  output logic [DATA_W-1:0] val_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              illegal_o
);
  op_e               op;
  logic [DATA_W-1:0] a_c, b_c, b_raw, raw;
  logic [TAG_W-1:0]  b_tag_eff, join_tag, res_tag;
  logic [DATA_W-1:0] res_c;
  logic              b_used, bad;

  assign op        = op_e'(op_i);
  // absent b: implicit one in a's type (only add may rely on it)
  assign b_raw     = present_i[1] ? b_val_i : DATA_W'(1);
  assign b_tag_eff = present_i[1] ? b_tag_i : a_tag_i;
  assign b_used    = (op != OP_CAST) && present_i[1];

  tag_canon #(.DATA_W(DATA_W)) u_canon_a (.val_i(a_val_i), .tag_i(a_tag_i),   .val_o(a_c));
  tag_canon #(.DATA_W(DATA_W)) u_canon_b (.val_i(b_raw),   .tag_i(b_tag_eff), .val_o(b_c));
  tag_join u_join (.a_tag_i(a_tag_i), .b_tag_i(b_tag_eff), .tag_o(join_tag));

  always_comb begin
    raw     = '0;
    res_tag = join_tag;
    unique case (op)
      OP_ADD:  raw = a_c + b_c;
      OP_SUB:  raw = a_c - b_c;
      OP_AND:  raw = a_c & b_c;
      OP_OR:   raw = a_c | b_c;
      OP_XOR:  raw = a_c ^ b_c;
      OP_LT: begin
        raw     = DATA_W'(tag_sgn(a_tag_i) ? ($signed(a_c) < $signed(b_c)) : (a_c < b_c));
        res_tag = T_U8;
      end
      OP_EQ: begin
        raw     = DATA_W'(a_c == b_c);
        res_tag = T_U8;
      end
      OP_CAST: begin
        raw     = a_c;
        res_tag = cast_tag_i;
      end
      default: ;
    endcase
  end

  tag_canon #(.DATA_W(DATA_W)) u_canon_r (.val_i(raw), .tag_i(res_tag), .val_o(res_c));

  always_comb begin
    bad = !present_i[0] || !tag_ok(a_tag_i) || (b_used && !tag_ok(b_tag_i));
    if (op == OP_CAST) bad = bad || !tag_ok(cast_tag_i);
    if (op != OP_ADD && op != OP_CAST && !present_i[1]) bad = 1'b1;
  end

  assign illegal_o = bad;
  assign val_o     = bad ? '0 : res_c;
  assign tag_o     = bad ? T_U8 : res_tag;
endmodule

// File: rtl/tagged_alu.sv
`timescale 1ns/1ps
module tagged_alu
  import tagged_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        present_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [3:0]        a_tag_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [3:0]        b_tag_i,
  input  logic [3:0]        cast_tag_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_val_o,
  output logic [3:0]        res_tag_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] val_d;
  logic [TAG_W-1:0]  tag_d;
  logic              ill_d;

  tagged_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i       (op_i),
    .present_i  (present_i),
    .a_val_i    (a_val_i),
    .a_tag_i    (a_tag_i),
    .b_val_i    (b_val_i),
    .b_tag_i    (b_tag_i),
    .cast_tag_i (cast_tag_i),
    .val_o      (val_d),
    .tag_o      (tag_d),
    .illegal_o  (ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_val_o   <= '0;
      res_tag_o   <= '0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_val_o <= val_d;
        res_tag_o <= tag_d;
        illegal_o <= ill_d;
      end
    end
  end
endmodule

// File: rtl/tagged_alu_chk.sv
`timescale 1ns/1ps
module tagged_alu_chk
  import tagged_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [2:0]        op_i,
  input logic [1:0]        present_i,
  input logic [DATA_W-1:0] a_val_i,
  input logic [3:0]        a_tag_i,
  input logic [3:0]        cast_tag_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_val_o,
  input logic [3:0]        res_tag_o,
  input logic              illegal_o
);
  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> res_valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !res_valid_o);
  // R7
  cmp_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i == 3'd5 || op_i == 3'd6))
      |=> (illegal_o || (res_tag_o == T_U8 && res_val_o[DATA_W-1:1] == '0)));
  // R4
  canon_u8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !illegal_o && res_tag_o == T_U8) |-> res_val_o[DATA_W-1:8] == '0);
  // R4
  canon_i16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !illegal_o && res_tag_o == T_I16)
      |-> res_val_o[DATA_W-1:16] == {(DATA_W-16){res_val_o[15]}});
  // R1
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && illegal_o) |-> (res_val_o == '0 && res_tag_o == T_U8));
  // R1
  tag_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !illegal_o) |-> res_tag_o <= T_PTR);
  // R6
  cast_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd7 && present_i[0] && tag_ok(a_tag_i) && tag_ok(cast_tag_i))
      |=> (!illegal_o && res_tag_o == $past(cast_tag_i)));
  // R5
  inc_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd0 && present_i == 2'b01 && tag_ok(a_tag_i))
      |=> (res_tag_o == $past(a_tag_i)));
  // R6: cast of a 64-bit target keeps the canonical a unchanged in width
  cast_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd7 && present_i[0] && a_tag_i == T_U64 && cast_tag_i == T_U64)
      |=> res_val_o == $past(a_val_i));
endmodule

bind tagged_alu tagged_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .present_i   (present_i),
  .a_val_i     (a_val_i),
  .a_tag_i     (a_tag_i),
  .cast_tag_i  (cast_tag_i),
  .res_valid_o (res_valid_o),
  .res_val_o   (res_val_o),
  .res_tag_o   (res_tag_o),
  .illegal_o   (illegal_o)
);

// File: tb/sim_tagged_alu.sv
`timescale 1ns/1ps
module sim_tagged_alu;
  localparam int DATA_W = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic [2:0]        op_i = '0;
  logic [1:0]        present_i = '0;
  logic [DATA_W-1:0] a_val_i = '0, b_val_i = '0;
  logic [3:0]        a_tag_i = '0, b_tag_i = '0, cast_tag_i = '0;
  logic              res_valid_o, illegal_o;
  logic [DATA_W-1:0] res_val_o;
  logic [3:0]        res_tag_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tagged_alu #(.DATA_W(DATA_W)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, sample one negedge later (result registered on the posedge between)
  task automatic run(input string req, input logic [2:0] op, input logic [1:0] pres,
                     input logic [63:0] a, input logic [3:0] at,
                     input logic [63:0] b, input logic [3:0] bt, input logic [3:0] ct,
                     input logic [63:0] ev, input logic [3:0] et, input logic eill);
    @(negedge clk_i);
    in_valid_i = 1'b1; op_i = op; present_i = pres;
    a_val_i = a; a_tag_i = at; b_val_i = b; b_tag_i = bt; cast_tag_i = ct;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk({req, " valid"}, 64'(res_valid_o), 64'd1);
    chk({req, " value"}, res_val_o, ev);
    chk({req, " tag"}, 64'(res_tag_o), 64'(et));
    chk({req, " illegal"}, 64'(illegal_o), 64'(eill));
  endtask

  task automatic t_reset();
    chk("R8 reset valid", 64'(res_valid_o), 64'd0);
    chk("R8 reset value", res_val_o, 64'd0);
    chk("R8 reset tag", 64'(res_tag_o), 64'd0);
    chk("R8 reset illegal", 64'(illegal_o), 64'd0);
  endtask

  task automatic t_arith();
    run("R2 add u8 wrap", 3'd0, 2'b11, 64'hF0, 4'd0, 64'h20, 4'd0, 4'd0, 64'h10, 4'd0, 1'b0);
    run("R4 sub u32", 3'd1, 2'b11, 64'h0, 4'd2, 64'h1, 4'd2, 4'd0, 64'h0000_0000_FFFF_FFFF, 4'd2, 1'b0);
    run("R4 sub i32", 3'd1, 2'b11, 64'h0, 4'd6, 64'h1, 4'd6, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd6, 1'b0);
    run("R2 xor narrow inputs", 3'd4, 2'b11, 64'hFFFF_FF00_0000_00AA, 4'd0, 64'h0F, 4'd0, 4'd0,
        64'hA5, 4'd0, 1'b0);
    run("R2 and sext input", 3'd2, 2'b11, 64'hFF00_FF00_FF00_FF00, 4'd3, 64'h8F, 4'd4, 4'd0,
        64'hFF00_FF00_FF00_FF00, 4'd3, 1'b0);
  endtask

  task automatic t_join();
    run("R3 wider signed", 3'd0, 2'b11, 64'h80, 4'd4, 64'h1, 4'd5, 4'd0,
        64'hFFFF_FFFF_FFFF_FF81, 4'd5, 1'b0);
    run("R3 mixed sign equal width", 3'd0, 2'b11, 64'hFFFF, 4'd1, 64'h1, 4'd5, 4'd0, 64'h0, 4'd1, 1'b0);
    run("R3 pointer wins", 3'd3, 2'b11, 64'h1000, 4'd8, 64'h0F, 4'd0, 4'd0, 64'h100F, 4'd8, 1'b0);
  endtask

  task automatic t_inc();
    run("R5 inc u8 wrap", 3'd0, 2'b01, 64'hFF, 4'd0, 64'h55, 4'd0, 4'd0, 64'h0, 4'd0, 1'b0);
    run("R5 inc i8 overflow", 3'd0, 2'b01, 64'h7F, 4'd4, 64'h55, 4'd9, 4'd0,
        64'hFFFF_FFFF_FFFF_FF80, 4'd4, 1'b0);
    run("R5 inc u64 wrap", 3'd0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3, 64'h0, 4'd0, 4'd0,
        64'h0, 4'd3, 1'b0);
  endtask

  task automatic t_cmp();
    run("R7 lt signed", 3'd5, 2'b11, 64'h80, 4'd4, 64'h01, 4'd4, 4'd0, 64'h1, 4'd0, 1'b0);
    run("R7 lt unsigned", 3'd5, 2'b11, 64'h01, 4'd0, 64'hFF, 4'd4, 4'd0, 64'h1, 4'd0, 1'b0);
    run("R7 lt signed false", 3'd5, 2'b11, 64'h01, 4'd4, 64'hFF, 4'd4, 4'd0, 64'h0, 4'd0, 1'b0);
    run("R7 eq across widths", 3'd6, 2'b11, 64'h05, 4'd0, 64'hAB00_0005, 4'd5, 4'd0, 64'h1, 4'd0, 1'b0);
    run("R7 eq canonical differ", 3'd6, 2'b11, 64'hFF, 4'd4, 64'hFF, 4'd0, 4'd0, 64'h0, 4'd0, 1'b0);
  endtask

  task automatic t_cast();
    run("R6 cast u64 to i8", 3'd7, 2'b01, 64'h80, 4'd3, 64'h0, 4'd0, 4'd4,
        64'hFFFF_FFFF_FFFF_FF80, 4'd4, 1'b0);
    run("R6 cast i8 to u16", 3'd7, 2'b01, 64'hFFFF_FFFF_FFFF_FF80, 4'd4, 64'h0, 4'd0, 4'd1,
        64'hFF80, 4'd1, 1'b0);
    run("R6 cast raw i8 to i64", 3'd7, 2'b01, 64'h80, 4'd4, 64'h0, 4'd0, 4'd7,
        64'hFFFF_FFFF_FFFF_FF80, 4'd7, 1'b0);
    run("R6 cast ignores b", 3'd7, 2'b11, 64'h8000_0000, 4'd6, 64'h1234, 4'd15, 4'd7,
        64'hFFFF_FFFF_8000_0000, 4'd7, 1'b0);
  endtask

  task automatic t_illegal();
    run("R1 reserved cast target", 3'd7, 2'b01, 64'h12, 4'd0, 64'h0, 4'd0, 4'd9, 64'h0, 4'd0, 1'b1);
    run("R1 reserved a tag", 3'd0, 2'b11, 64'h12, 4'd12, 64'h1, 4'd0, 4'd0, 64'h0, 4'd0, 1'b1);
    run("R1 reserved b tag", 3'd3, 2'b11, 64'h12, 4'd0, 64'h1, 4'd15, 4'd0, 64'h0, 4'd0, 1'b1);
    run("R9 and without b", 3'd2, 2'b01, 64'h12, 4'd0, 64'h1, 4'd0, 4'd0, 64'h0, 4'd0, 1'b1);
    run("R9 add without a", 3'd0, 2'b10, 64'h12, 4'd0, 64'h1, 4'd0, 4'd0, 64'h0, 4'd0, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    chk("R8 idle valid low", 64'(res_valid_o), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #25;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_arith();
    t_idle();
    t_join();
    t_inc();
    t_cmp();
    t_cast();
    t_illegal();
    t_idle();
    finish_run();
  end

  initial begin
    #2000000;
    vecs++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule